// File: doc/BRIEF.md
# I2C Clock-Enable Configuration Slave

This block is a two-wire serial slave that holds the run/stop settings for a bank of buffered clock outputs. A fast system clock oversamples the serial clock and data lines. The block finds start and stop conditions and answers only to its own device address. It keeps three 8-bit configuration bytes, and each bit lets one copy of an incoming reference clock run or holds it low. A thin gating stage sits after the registers. It stops each output only at a falling edge of the reference clock, so no shortened high pulse ever reaches a pad. A global output-enable input produces the pad drive enable.

A write carries two leading bytes after the address. Both are acknowledged and discarded. The data bytes that follow always fill the configuration bytes from the lowest upward, and the controller may stop after any whole byte. A read needs no leading bytes: it streams the configuration bytes from the lowest upward until the controller declines a byte. The data pin is driven only as an open-drain pull-down request. The block uses no register addressing and does not depend on the bus rate, provided each serial clock phase lasts several system clocks.

Top module: `clkfan_cfg_slave`

## Requirements
- R1: After reset every configuration bit is 1, so all eighteen enables are high and every output follows the reference clock.
- R2: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read). For any other address byte it leaves the data line released during the acknowledge slot and ignores the rest of the transfer.
- R3: In a write, the slave acknowledges the two bytes after the address and discards them. It then acknowledges each data byte and stores the first into configuration byte 0, the second into byte 1 and the third into byte 2.
- R4: Enable k for k in 0..7 is byte 0 bit k, and enable k for k in 8..15 is byte 1 bit k-8. Enable 17 is byte 2 bit 7 and enable 16 is byte 2 bit 6. Byte 2 bits 5..0 drive no enable but are stored and read back.
- R5: A read returns configuration byte 0 first, then bytes 1 and 2 in order, for as long as the controller acknowledges. There are no leading bytes.
- R6: A write may end with STOP after any complete data byte. Bytes already stored keep their new values, and the bytes not reached keep their old values.
- R7: In a write, data bytes beyond byte 2 are acknowledged and discarded. In a read, every byte beyond byte 2 reads as 0xFF.
- R8: A data byte cut short by STOP or by a repeated START changes no configuration bit.
- R9: An output whose enable is 0 stays low through later reference clock cycles. An enabled output follows the reference clock.
- R10: Clearing an enable while the reference clock is high leaves the output high until the next falling reference edge. The output stays low from that edge on.
- R11: With the output-enable input low, the pad drive enable is low whatever the configuration holds. The configuration bits are not affected.
- R12: The slave changes its data-line pull-down only while the serial clock is low, and it releases the line after STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 requests the pad to pull the data line low |
| buf_clk | input | 1 | Reference clock copied to the outputs |
| oe_in | input | 1 | Global output enable, 0 tristates all outputs |
| clk_en | output | 18 | Per-output enable bits from the configuration |
| clk_out | output | 18 | Gated copies of the reference clock |
| clk_drv | output | 1 | Pad drive enable for all clock outputs |

## Verification
A wrong receive state, such as a miscounted bit or a wrong byte role, shows up as a missing or misplaced acknowledge within the same byte. It also shows up at the enable pins one byte later as a value shifted by one position. A wrong write pointer puts data in the neighbouring byte, and a wrong read pointer returns a byte out of order. Both appear in the first read-back after the transfer. A fault in the gating stage appears on the first falling reference edge after an enable change, as a stopped output that still toggles or as a high phase that is cut short.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_RACK
   } bus_state_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_SKIP0,
      PH_SKIP1,
      PH_DATA
   } byte_role_e;

endpackage

// File: rtl/clkfan_sync.sv
module clkfan_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clkfan_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkfan_i2c_rx.sv
module clkfan_i2c_rx
   import clkfan_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_BYTES   = 3,
   parameter int         SYNC_STAGES = 2,
   localparam int        IDXW        = $clog2(NUM_BYTES + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull,
   output logic              wr_stb,
   output logic [IDXW-1:0]   wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic [IDXW-1:0]   rd_idx,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              scl_sync,
   output logic              stop_det
);
   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_BYTES);

   logic scl_s, sda_s, scl_d, sda_d;
   logic start_det, scl_rise, scl_fall;

   clkfan_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   clkfan_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign scl_sync  = scl_s;

   bus_state_e        state;
   byte_role_e        role;
   logic              rd_mode, m_ack, pull_q;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic [IDXW-1:0]   wr_ptr, rd_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         role    <= PH_ADDR;
         rd_mode <= 1'b0;
         m_ack   <= 1'b0;
         pull_q  <= 1'b0;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         wr_stb  <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (stop_det) begin
            state  <= ST_IDLE;
            pull_q <= 1'b0;
         end else if (start_det) begin
            state   <= ST_RX;
            role    <= PH_ADDR;
            bit_cnt <= '0;
            pull_q  <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && bit_cnt != 4'd8) begin
                     rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     state  <= ST_ACK;
                     pull_q <= 1'b1;
                     case (role)
                        PH_ADDR: begin
                           if (rx_sh[7:1] == DEV_ADDR) begin
                              rd_mode <= rx_sh[0];
                              rd_ptr  <= '0;
                              role    <= PH_SKIP0;
                           end else begin
                              state  <= ST_IDLE;
                              pull_q <= 1'b0;
                           end
                        end
                        PH_SKIP0: role <= PH_SKIP1;
                        PH_SKIP1: begin
                           role   <= PH_DATA;
                           wr_ptr <= '0;
                        end
                        PH_DATA: begin
                           if (wr_ptr != LAST_IDX) begin
                              wr_stb  <= 1'b1;
                              wr_idx  <= wr_ptr;
                              wr_data <= rx_sh;
                              wr_ptr  <= wr_ptr + IDXW'(1);
                           end
                        end
                        default: role <= PH_ADDR;
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (rd_mode) begin
                        tx_sh  <= rd_data;
                        pull_q <= ~rd_data[BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        pull_q <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd7) begin
                        pull_q <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                        pull_q  <= ~tx_sh[BYTE_W-2];
                        bit_cnt <= bit_cnt + 4'd1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_s;
                     if (!sda_s && rd_ptr != LAST_IDX) rd_ptr <= rd_ptr + IDXW'(1);
                  end else if (scl_fall) begin
                     if (m_ack) begin
                        tx_sh   <= rd_data;
                        pull_q  <= ~rd_data[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= ST_TX;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: pull_q <= 1'b0;
            endcase
         end
      end
   end

   assign sda_pull = pull_q;
   assign rd_idx   = rd_ptr;
endmodule

// File: rtl/clkfan_regs.sv
module clkfan_regs
   import clkfan_pkg::*;
#(
   parameter int  NUM_BYTES = 3,
   parameter int  NUM_OUT   = 18,
   localparam int IDXW      = $clog2(NUM_BYTES + 1)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stb,
   input  logic [IDXW-1:0]      wr_idx,
   input  logic [BYTE_W-1:0]    wr_data,
   input  logic [IDXW-1:0]      rd_idx,
   output logic [BYTE_W-1:0]    rd_data,
   output logic [NUM_BYTES-1:0] byte_we,
   output logic [NUM_OUT-1:0]   clk_en
);
   if (NUM_OUT < 1 || NUM_OUT > BYTE_W * NUM_BYTES) begin : g_bad_map
      $error("clkfan_regs: NUM_OUT does not fit in NUM_BYTES");
   end

   logic [BYTE_W-1:0] cfg_q [NUM_BYTES];

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      assign byte_we[b] = wr_stb && (wr_idx == IDXW'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cfg_q[b] <= '1;
         else if (byte_we[b]) cfg_q[b] <= wr_data;
      end
   end

   // Outputs of a partly filled top byte sit in its upper bits.
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_map
      localparam int B     = i / BYTE_W;
      localparam int FIRST = B * BYTE_W;
      localparam int K     = (NUM_OUT - FIRST >= BYTE_W) ? BYTE_W : NUM_OUT - FIRST;
      localparam int P     = BYTE_W - K + (i - FIRST);
      assign clk_en[i] = cfg_q[B][P];
   end

   always_comb begin
      rd_data = '1;
      for (int b = 0; b < NUM_BYTES; b++) begin
         if (rd_idx == IDXW'(b)) rd_data = cfg_q[b];
      end
   end
endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate #(
   parameter int NUM_OUT     = 18,
   parameter bit GLITCH_FREE = 1'b1
)(
   input  logic               buf_clk,
   input  logic               rst_n,
   input  logic [NUM_OUT-1:0] en,
   output logic [NUM_OUT-1:0] gate_q,
   output logic [NUM_OUT-1:0] clk_out
);
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      if (GLITCH_FREE) begin : g_safe
         always_ff @(negedge buf_clk or negedge rst_n) begin
            if (!rst_n) gate_q[i] <= 1'b1;
            else        gate_q[i] <= en[i];
         end
      end else begin : g_direct
         assign gate_q[i] = en[i];
      end
      assign clk_out[i] = buf_clk & gate_q[i];
   end
endmodule

// File: rtl/clkfan_cfg_slave.sv
module clkfan_cfg_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_BYTES   = 3,
   parameter int         NUM_OUT     = 18,
   parameter int         SYNC_STAGES = 2,
   parameter bit         GLITCH_FREE = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   output logic               sda_pull,
   input  logic               buf_clk,
   input  logic               oe_in,
   output logic [NUM_OUT-1:0] clk_en,
   output logic [NUM_OUT-1:0] clk_out,
   output logic               clk_drv
);
   localparam int IDXW = $clog2(NUM_BYTES + 1);

   if (NUM_BYTES < 1) begin : g_bad_bytes
      $error("clkfan_cfg_slave: NUM_BYTES must be positive");
   end

   logic                 wr_stb, scl_sync, stop_det;
   logic [IDXW-1:0]      wr_idx, rd_idx;
   logic [7:0]           wr_data, rd_data;
   logic [NUM_BYTES-1:0] byte_we;
   logic [NUM_OUT-1:0]   gate_q;

   clkfan_i2c_rx #(
      .DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES), .SYNC_STAGES(SYNC_STAGES)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .sda_pull(sda_pull), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .scl_sync(scl_sync), .stop_det(stop_det)
   );

   clkfan_regs #(.NUM_BYTES(NUM_BYTES), .NUM_OUT(NUM_OUT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .byte_we(byte_we), .clk_en(clk_en)
   );

   clkfan_gate #(.NUM_OUT(NUM_OUT), .GLITCH_FREE(GLITCH_FREE)) u_gate (
      .buf_clk(buf_clk), .rst_n(rst_n), .en(clk_en),
      .gate_q(gate_q), .clk_out(clk_out)
   );

   assign clk_drv = oe_in;
endmodule

// File: rtl/clkfan_cfg_slave_chk.sv
module clkfan_cfg_slave_chk #(
   parameter int NUM_BYTES   = 3,
   parameter int NUM_OUT     = 18,
   parameter bit GLITCH_FREE = 1'b1
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 scl_sync,
   input logic                 stop_det,
   input logic                 sda_pull,
   input logic                 wr_stb,
   input logic [NUM_BYTES-1:0] byte_we,
   input logic                 buf_clk,
   input logic [NUM_OUT-1:0]   clk_en,
   input logic [NUM_OUT-1:0]   gate_q
);
   // R8
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(clk_en));

   // R8
   commit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|byte_we) |-> !scl_sync);

   // R12
   sda_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_sync && $past(scl_sync)) |-> $stable(sda_pull));

   // R12
   sda_stop_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull);

   if (GLITCH_FREE) begin : g_gate_chk
      // R10
      gate_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (buf_clk && $past(buf_clk)) |-> $stable(gate_q));
   end
endmodule

bind clkfan_cfg_slave clkfan_cfg_slave_chk #(
   .NUM_BYTES(NUM_BYTES), .NUM_OUT(NUM_OUT), .GLITCH_FREE(GLITCH_FREE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .stop_det(stop_det),
   .sda_pull(sda_pull), .wr_stb(wr_stb), .byte_we(byte_we),
   .buf_clk(buf_clk), .clk_en(clk_en), .gate_q(gate_q)
);

// File: tb/clkfan_cfg_slave_bench.sv
module clkfan_cfg_slave_bench;
   localparam int Q = 25;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic buf_free = 1'b0, buf_man = 1'b0, buf_run = 1'b1;
   logic oe_in = 1'b1;
   logic sda_pull, clk_drv;
   logic [17:0] clk_en, clk_out;
   wire  sda_line = sda_m & ~sda_pull;
   wire  buf_clk  = buf_run ? buf_free : buf_man;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   logic [7:0] model [3];
   logic [7:0] wbuf [8];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] rd_last;
   event       rd_ev;

   clkfan_cfg_slave u_clkfan_cfg_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_pull(sda_pull), .buf_clk(buf_clk), .oe_in(oe_in),
      .clk_en(clk_en), .clk_out(clk_out), .clk_drv(clk_drv)
   );

   always #10 clk = ~clk;
   always begin #100; buf_free = ~buf_free; end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [17:0] exp_en();
      return {model[2][7], model[2][6], model[1], model[0]};
   endfunction

   task automatic hq(); repeat (Q) @(negedge clk); endtask
   task automatic bus_start(); sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; hq(); endtask
   task automatic bus_stop();  sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq(); endtask
   task automatic put_bit(input logic b); sda_m = b; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq(); endtask
   task automatic get_bit(output logic b); sda_m = 1; hq(); scl_m = 1; hq(); b = sda_line; hq(); scl_m = 0; hq(); endtask

   task automatic put_byte(input logic [7:0] v, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      ack = ~a;
   endtask

   task automatic get_byte(input logic give_ack);
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) get_bit(v[i]);
      put_bit(~give_ack);
      rd_last = v;
      -> rd_ev;
   endtask

   // Driver: full write of n data bytes; the model follows R3/R7.
   task automatic send_write(input int n, input string tag);
      logic a;
      bus_start();
      put_byte(8'hD2, a); check("R2 write address ack", a, 1);
      put_byte(8'h3C, a); check("R3 command byte ack", a, 1);
      put_byte(8'h07, a); check("R3 count byte ack", a, 1);
      for (int k = 0; k < n; k++) begin
         put_byte(wbuf[k], a);
         check(k < 3 ? "R3 data ack" : "R7 extra data ack", a, 1);
         if (k < 3) model[k] = wbuf[k];
      end
      bus_stop(); hq();
      check(tag, clk_en, exp_en());
      check("R12 released after stop", sda_pull, 0);
   endtask

   // Driver: read n bytes, expected items pushed to the scoreboard.
   task automatic send_read(input int n, input string tag);
      logic a;
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(k < 3 ? model[k] : 8'hFF);
         tag_q.push_back(k < 3 ? tag : "R7 read beyond last byte");
      end
      bus_start();
      put_byte(8'hD3, a); check("R2 read address ack", a, 1);
      for (int k = 0; k < n; k++) get_byte(k < n - 1);
      bus_stop(); hq();
   endtask

   // Monitor: pops expected items as bytes arrive.
   initial begin
      forever begin
         @(rd_ev);
         if (exp_q.size() == 0) begin
            check("R5 unexpected read byte", rd_last, 8'hxx);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(t, rd_last, e);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic a;
      int bad, hi;
      for (int k = 0; k < 3; k++) model[k] = 8'hFF;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 reset enables", clk_en, 18'h3FFFF);
      check("R1 reset pull released", sda_pull, 0);
      check("R11 drive on with oe high", clk_drv, 1);

      // R2: foreign address is not acknowledged and changes nothing
      bus_start();
      put_byte(8'hA0, a); check("R2 foreign address nack", a, 0);
      put_byte(8'h00, a); check("R2 foreign data nack", a, 0);
      bus_stop(); hq();
      check("R2 foreign write ignored", clk_en, 18'h3FFFF);

      // R3/R4: full write, mapping of byte 2 upper bits
      wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h80;
      send_write(3, "R4 enable mapping");
      check("R4 output 17 from byte2 bit7", clk_en[17], 1);
      check("R4 output 16 from byte2 bit6", clk_en[16], 0);

      // R5/R7: read-back plus one byte beyond
      send_read(4, "R5 read order");

      // R6: stop after one complete byte
      wbuf[0] = 8'h0F;
      send_write(1, "R6 partial write keeps upper bytes");

      // R8: byte cut off by STOP
      bus_start();
      put_byte(8'hD2, a); put_byte(8'h11, a); put_byte(8'h22, a);
      put_byte(8'hF0, a); check("R8 data ack before cut", a, 1);
      model[0] = 8'hF0;
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      bus_stop(); hq();
      check("R8 cut byte at stop not stored", clk_en, exp_en());

      // R8: byte cut off by repeated START, then read back
      bus_start();
      put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h00, a);
      put_byte(8'hAA, a);
      model[0] = 8'hAA;
      for (int i = 0; i < 3; i++) put_bit(1'b0);
      exp_q.push_back(model[0]); tag_q.push_back("R8 read after repeated start");
      exp_q.push_back(model[1]); tag_q.push_back("R8 byte1 untouched");
      bus_start();
      put_byte(8'hD3, a); check("R2 read address after repeated start", a, 1);
      get_byte(1'b1); get_byte(1'b0);
      bus_stop(); hq();
      check("R8 enables after repeated start", clk_en, exp_en());

      // R7: extra write data discarded; reserved bits read back (R4)
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      send_write(4, "R7 extra write discarded");
      send_read(4, "R4 reserved bits read back");

      // R9: outputs 16, 17 and 1 disabled, output 0 running
      bad = 0; hi = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (clk_out[17] || clk_out[16] || clk_out[1]) bad++;
         if (clk_out[0]) hi++;
      end
      check("R9 disabled outputs held low", bad, 0);
      check("R9 enabled output toggles", hi > 0, 1);

      // R10: stop requested during a high phase
      @(posedge buf_free);
      buf_man = 1'b1; buf_run = 1'b0;
      wbuf[0] = 8'hFE;
      send_write(1, "R10 enable cleared");
      check("R10 enable bit low", clk_en[0], 0);
      check("R10 high phase not cut", clk_out[0], 1);
      buf_man = 1'b0; repeat (3) @(negedge clk);
      check("R10 low after falling edge", clk_out[0], 0);
      buf_man = 1'b1; repeat (3) @(negedge clk);
      check("R10 stays low next high phase", clk_out[0], 0);
      check("R9 enabled neighbour follows clock", clk_out[1], 1);
      @(posedge buf_free);
      buf_run = 1'b1;

      // R11: global output enable
      oe_in = 1'b0; repeat (3) @(negedge clk);
      check("R11 drive off with oe low", clk_drv, 0);
      check("R11 config unaffected", clk_en, exp_en());
      oe_in = 1'b1; repeat (3) @(negedge clk);
      check("R11 drive back on", clk_drv, 1);

      repeat (10) @(negedge clk);
      check("R5 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule